// File: doc/BRIEF.md
# Time-Slotted Slave Polling Master

This block is the bus-master sequencer for a shared synchronous full-duplex serial bus with several slave nodes. It alone starts every exchange. It walks through the slaves in a fixed repeating order and gives each slave one timeslot per round. During a slot it raises that slave's select, tells the frame layers which kind of word to put on the wire, and tracks what comes back. The word shifter is outside the block. It is reached through a word strobe, `word_done`, which pulses once for every word shifted in both directions. Two receive qualifiers arrive with that strobe.

Before any payload moves, a startup pass visits every slave once and marks a few word times as configuration words. The maximum frame length is presented on `cfg_word` during those words. After that the block runs slots without end. Each slot opens with a one-cycle start strobe. A probe word follows. If neither side has data, the slot closes right after the probe; this is the short empty slot. Otherwise the data phase runs for the slave's own slot length, which can differ from slave to slave. If the master sent a frame, an acknowledge poll follows, made of default words. If that poll gets no acknowledge reply, the block raises a timeout pulse for that slave. If the slave sent data, the master answers with one acknowledge word. A one-cycle recovery gap with no slave selected ends every slot.

Top module: `tdma_poll_master`

## Requirements
- R1: After reset the block selects slaves 0 to N-1 in turn. Each stays selected for SYNC_WORDS word strobes, with `tx_kind` = 3 (configuration) and `cfg_word` = MAX_FRAME. `cfg_word` is 0 outside this pass.
- R2: `sel` is one-hot while a slot or the startup pass runs. It is all zero for exactly one recovery cycle between slots. Slots visit the slaves in ascending order and wrap from N-1 to 0.
- R3: `slot_start` is a one-cycle pulse in the first cycle of every slot. In that cycle the slave is already selected and `tx_kind` = 0 (default word).
- R4: While data words are sent, `tx_kind` is 1 (frame) if `m_pending` for that slave was set in the slot's start cycle, and 0 otherwise. The data phase, counting the probe word, lasts exactly the slave's slot length in word strobes. A programmed length of 0 acts as 1.
- R5: If no master frame is pending and the probe word's strobe comes with `rx_has_data` low, the slot ends after that single word. This is the empty slot.
- R6: When the master sent a frame, up to ACK_WAIT default words follow. A strobe with `ack_rx` high ends the poll. If none arrives, `app_tout[idx]` pulses for one cycle together with the last poll strobe.
- R7: If `rx_has_data` was high on any data-phase strobe, exactly one word with `tx_kind` = 2 (acknowledge) follows the data and poll phases.
- R8: Apart from the single-cycle start and recovery states, the sequence advances only on `word_done`. Between strobes, `sel` holds.
- R9: Changes to `m_pending` after a slot's start cycle have no effect on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_done | input | 1 | One word has been exchanged on the bus |
| rx_has_data | input | 1 | With `word_done`: the received word is not a default word |
| ack_rx | input | 1 | With `word_done`: a valid ACK or NACK reply was received |
| m_pending | input | N | Master has a frame queued for each slave |
| slot_len_cfg | input | N*SLOT_W | Per-slave slot length in word times, slave 0 in the low bits |
| sel | output | N | One-hot slave select |
| tx_kind | output | 2 | Word to send: 0 default, 1 frame, 2 acknowledge, 3 configuration |
| cfg_word | output | WORD_W | Maximum frame length during the startup pass, else 0 |
| slot_start | output | 1 | First cycle of a slot |
| app_tout | output | N | Per-slave acknowledge timeout pulse |

## Verification
`sel`, `tx_kind`, `cfg_word` and `slot_start` come from the state register. They change in the cycle after the clock edge that sees a `word_done`, and the single-cycle start and gap states add exactly one cycle each. `app_tout` is combinational on the last poll strobe, so it is due in the same cycle as that strobe. The bench drives inputs on the falling edge and samples every output 2 ns later. Its behavioural model steps on the rising edge, so each comparison sees the state one edge after the stimulus, and for the timeout pulse it also sees the stimulus itself.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        TX_DFW   = 2'd0,
        TX_FRAME = 2'd1,
        TX_ACK   = 2'd2,
        TX_CFG   = 2'd3
    } tx_kind_t;

    typedef enum logic [2:0] {
        ST_SYNC,
        ST_OPEN,
        ST_PROBE,
        ST_DATA,
        ST_APOLL,
        ST_ACKTX,
        ST_GAP
    } poll_st_t;

endpackage

// File: rtl/tdma_len_pick.sv
module tdma_len_pick #(
    parameter int N      = 4,
    parameter int SLOT_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [N*SLOT_W-1:0] cfg,
    input  logic [IDX_W-1:0]    idx,
    output logic [SLOT_W-1:0]   len
);
    logic [SLOT_W-1:0] lens [N];

    // Unpack the flat config bus; a zero length is clamped to one word.
    for (genvar g = 0; g < N; g++) begin : g_unpack
        always_comb begin
            lens[g] = cfg[g*SLOT_W +: SLOT_W];
            if (lens[g] == '0) lens[g] = SLOT_W'(1);
        end
    end

    always_comb begin
        len = lens[0];
        for (int i = 0; i < N; i++)
            if (idx == IDX_W'(i)) len = lens[i];
    end
endmodule

// File: rtl/tdma_sel_decode.sv
module tdma_sel_decode #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             en,
    input  logic             fire,
    output logic [N-1:0]     sel,
    output logic [N-1:0]     tout
);
    for (genvar g = 0; g < N; g++) begin : g_dec
        assign sel[g]  = en   && (idx == IDX_W'(g));
        assign tout[g] = fire && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/tdma_poll_master.sv
module tdma_poll_master
    import tdma_pkg::*;
#(
    parameter int N          = 4,
    parameter int SLOT_W     = 8,
    parameter int WORD_W     = 8,
    parameter int ACK_WAIT   = 4,
    parameter int SYNC_WORDS = 2,
    parameter int MAX_FRAME  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_done,
    input  logic                rx_has_data,
    input  logic                ack_rx,
    input  logic [N-1:0]        m_pending,
    input  logic [N*SLOT_W-1:0] slot_len_cfg,
    output logic [N-1:0]        sel,
    output logic [1:0]          tx_kind,
    output logic [WORD_W-1:0]   cfg_word,
    output logic                slot_start,
    output logic [N-1:0]        app_tout
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [SLOT_W-1:0] ONE       = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] ACK_LAST  = SLOT_W'(ACK_WAIT - 1);
    localparam logic [SLOT_W-1:0] SYNC_LAST = SLOT_W'(SYNC_WORDS - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N - 1);

    poll_st_t          st, nxt;
    logic [IDX_W-1:0]  idx;
    logic [SLOT_W-1:0] wcnt;
    logic [SLOT_W-1:0] len;
    logic              m_tx, s_tx;
    logic              tout_fire;

    tdma_len_pick #(.N(N), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_len (
        .cfg(slot_len_cfg), .idx(idx), .len(len)
    );

    tdma_sel_decode #(.N(N), .IDX_W(IDX_W)) u_dec (
        .idx(idx), .en(st != ST_GAP), .fire(tout_fire),
        .sel(sel), .tout(app_tout)
    );

    function automatic poll_st_t after_data(input logic mt, input logic sd);
        if (mt)      return ST_APOLL;
        else if (sd) return ST_ACKTX;
        else         return ST_GAP;
    endfunction

    // Next-state logic
    always_comb begin
        nxt       = st;
        tout_fire = 1'b0;
        unique case (st)
            ST_SYNC:  if (word_done && wcnt == SYNC_LAST && idx == LAST_IDX) nxt = ST_OPEN;
            ST_OPEN:  nxt = ST_PROBE;
            ST_PROBE: if (word_done) begin
                if (!m_tx && !rx_has_data) nxt = ST_GAP;
                else if (len == ONE)       nxt = after_data(m_tx, rx_has_data);
                else                       nxt = ST_DATA;
            end
            ST_DATA:  if (word_done && (wcnt + ONE) == len)
                nxt = after_data(m_tx, s_tx | rx_has_data);
            ST_APOLL: if (word_done) begin
                if (ack_rx) begin
                    nxt = s_tx ? ST_ACKTX : ST_GAP;
                end else if (wcnt == ACK_LAST) begin
                    tout_fire = 1'b1;
                    nxt = s_tx ? ST_ACKTX : ST_GAP;
                end
            end
            ST_ACKTX: if (word_done) nxt = ST_GAP;
            ST_GAP:   nxt = ST_OPEN;
            default:  nxt = ST_SYNC;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_SYNC;
        else        st <= nxt;
    end

    // Slave index, word counter and slot flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            wcnt <= '0;
            m_tx <= 1'b0;
            s_tx <= 1'b0;
        end else begin
            unique case (st)
                ST_SYNC: if (word_done) begin
                    if (wcnt == SYNC_LAST) begin
                        wcnt <= '0;
                        idx  <= (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
                    end else begin
                        wcnt <= wcnt + ONE;
                    end
                end
                ST_OPEN: begin
                    wcnt <= '0;
                    m_tx <= m_pending[idx];
                    s_tx <= 1'b0;
                end
                ST_PROBE, ST_DATA: if (word_done) begin
                    wcnt <= (nxt == ST_APOLL) ? '0 : wcnt + ONE;
                    s_tx <= s_tx | rx_has_data;
                end
                ST_APOLL: if (word_done) wcnt <= wcnt + ONE;
                ST_ACKTX: ;
                ST_GAP:   idx <= (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
                default:  ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        slot_start = (st == ST_OPEN);
        cfg_word   = (st == ST_SYNC) ? WORD_W'(MAX_FRAME) : '0;
        unique case (st)
            ST_SYNC:           tx_kind = TX_CFG;
            ST_PROBE, ST_DATA: tx_kind = m_tx ? TX_FRAME : TX_DFW;
            ST_ACKTX:          tx_kind = TX_ACK;
            default:           tx_kind = TX_DFW;
        endcase
    end
endmodule

// File: rtl/tdma_poll_checks.sv
module tdma_poll_checks #(
    parameter int N         = 4,
    parameter int WORD_W    = 8,
    parameter int MAX_FRAME = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_done,
    input logic              ack_rx,
    input logic [N-1:0]      sel,
    input logic [1:0]        tx_kind,
    input logic [WORD_W-1:0] cfg_word,
    input logic              slot_start,
    input logic [N-1:0]      app_tout
);
    assert_cfg_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_kind == 2'd3) |-> (cfg_word == WORD_W'(MAX_FRAME) && $onehot(sel)));

    assert_sel_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    assert_start_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> ($onehot(sel) && tx_kind == 2'd0));

    assert_tout_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|app_tout) |-> ($onehot(app_tout) && (app_tout & ~sel) == '0 && word_done && !ack_rx));

    assert_ack_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_kind == 2'd2) |-> $onehot(sel));

    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sel) && !word_done) |=> (sel == $past(sel)));
endmodule

bind tdma_poll_master tdma_poll_checks #(.N(N), .WORD_W(WORD_W), .MAX_FRAME(MAX_FRAME)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .ack_rx(ack_rx),
    .sel(sel), .tx_kind(tx_kind), .cfg_word(cfg_word),
    .slot_start(slot_start), .app_tout(app_tout)
);

// File: tb/sim_tdma_poll_master.sv
module sim_tdma_poll_master;
    localparam int N = 4, SLOT_W = 8, WORD_W = 8, ACK_WAIT = 4, SYNC_WORDS = 2, MAX_FRAME = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_done = 1'b0, rx_has_data = 1'b0, ack_rx = 1'b0;
    logic [N-1:0] m_pending = '0;
    // slave3=5, slave2=0 (acts as 1), slave1=1, slave0=3
    logic [N*SLOT_W-1:0] slot_len_cfg = {8'd5, 8'd0, 8'd1, 8'd3};
    logic [N-1:0] sel, app_tout;
    logic [1:0] tx_kind;
    logic [WORD_W-1:0] cfg_word;
    logic slot_start;

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tdma_poll_master #(.N(N), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .ACK_WAIT(ACK_WAIT),
                       .SYNC_WORDS(SYNC_WORDS), .MAX_FRAME(MAX_FRAME)) u0 (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .rx_has_data(rx_has_data),
        .ack_rx(ack_rx), .m_pending(m_pending), .slot_len_cfg(slot_len_cfg),
        .sel(sel), .tx_kind(tx_kind), .cfg_word(cfg_word),
        .slot_start(slot_start), .app_tout(app_tout)
    );

    // Behavioural reference: phase 0 sync,1 open,2 probe,3 data,4 ack poll,5 ack send,6 gap
    int ph, ix, cnt;
    bit mt, sd;
    int n_empty = 0, n_tout = 0, n_ackw = 0, n_zero = 0, n_frame = 0;

    function automatic int eff_len(input int i);
        int l;
        l = int'(slot_len_cfg[i*SLOT_W +: SLOT_W]);
        return (l == 0) ? 1 : l;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; ix = 0; cnt = 0; mt = 0; sd = 0;
        end else begin
            case (ph)
                0: if (word_done) begin
                    if (cnt == SYNC_WORDS - 1) begin
                        cnt = 0;
                        if (ix == N - 1) begin ix = 0; ph = 1; end
                        else ix++;
                    end else cnt++;
                end
                1: begin cnt = 0; mt = m_pending[ix]; sd = 0; ph = 2; end
                2, 3: if (word_done) begin
                    cnt++;
                    sd = sd | rx_has_data;
                    if (ph == 2 && !mt && !rx_has_data) begin
                        ph = 6; n_empty++;
                    end else if (cnt >= eff_len(ix)) begin
                        if (ix == 2) n_zero++;
                        if (mt) begin ph = 4; cnt = 0; n_frame++; end
                        else ph = sd ? 5 : 6;
                    end else ph = 3;
                end
                4: if (word_done) begin
                    if (ack_rx) ph = sd ? 5 : 6;
                    else if (cnt == ACK_WAIT - 1) begin ph = sd ? 5 : 6; n_tout++; end
                    else cnt++;
                end
                5: if (word_done) begin ph = 6; n_ackw++; end
                default: begin ix = (ix + 1) % N; ph = 1; end
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            logic [N-1:0] es, et;
            int ek;
            es = '0; et = '0;
            if (ph != 6) es[ix] = 1'b1;
            case (ph)
                0: ek = 3;
                2, 3: ek = mt ? 1 : 0;
                5: ek = 2;
                default: ek = 0;
            endcase
            if (ph == 4 && word_done && !ack_rx && cnt == ACK_WAIT - 1) et[ix] = 1'b1;
            check(sel == es, "R2 R8 sel", int'(sel), int'(es));
            check(int'(tx_kind) == ek, "R1 R4 R7 R9 tx_kind", int'(tx_kind), ek);
            check(cfg_word == ((ph == 0) ? WORD_W'(MAX_FRAME) : '0), "R1 cfg_word",
                  int'(cfg_word), (ph == 0) ? MAX_FRAME : 0);
            check(slot_start == (ph == 1), "R3 slot_start", int'(slot_start), int'(ph == 1));
            check(app_tout == et, "R6 app_tout", int'(app_tout), int'(et));
        end
    end

    task automatic run(input int cycles, input int p_wd, input int p_rx, input int p_ack, input int p_mp);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            word_done   = ($urandom % 100) < p_wd;
            rx_has_data = ($urandom % 100) < p_rx;
            ack_rx      = ($urandom % 100) < p_ack;
            for (int s = 0; s < N; s++) m_pending[s] = ($urandom % 100) < p_mp;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R1: reset state is slave 0 in the configuration pass
        check(sel == 4'b0001 && tx_kind == 2'd3 && cfg_word == 8'd32 && !slot_start && app_tout == '0,
              "R1 reset state", int'(sel), 1);
        run(1200, 80, 25, 40, 50);   // mixed traffic
        run(1200, 35, 40, 0, 70);    // no replies: timeouts, sparse strobes
        run(600, 90, 0, 0, 0);       // idle bus: empty slots
        run(1000, 100, 50, 30, 60);  // dense strobes
        @(negedge clk); #3;
        check(n_empty > 0, "R5 empty slots seen", n_empty, 1);
        check(n_tout > 0, "R6 timeouts seen", n_tout, 1);
        check(n_ackw > 0, "R7 ack words seen", n_ackw, 1);
        check(n_zero > 0, "R4 zero-length slots seen", n_zero, 1);
        check(n_frame > 0, "R9 frame slots seen", n_frame, 1);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule